// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with High-Impedance Sampling

This block is the serial test port of a memory device. It is clocked by a test clock and steered by a mode-select line, and it moves serial data in on one pin and out on another. A standard sixteen-state controller walks through the capture, shift and update phases of two register paths. The first path is a 3-bit instruction register. The second is one of three data registers, picked by the instruction: a 1-bit bypass stage, a fixed 32-bit identification word, or a boundary chain of `BSR_LEN` cells.

The boundary chain takes a parallel snapshot of the device pins during capture. It shifts that snapshot out while new values shift in, and it copies the shifted values to a parallel drive vector during update. The instruction set differs from the usual one in three ways. Two codes float the device's data outputs while the pins are sampled. One sampling code leaves those outputs alone. Four codes, one of them reserved, all select the bypass stage.

There is no separate test-reset pin. An active-low power-on reset puts the controller in its reset state, and holding the mode-select line high for five test-clock cycles does the same. On a board, both serial input pads need pull-ups so that a floating input reads as 1.

Top module: `tap_scan_port`

## Requirements
- R1: After power-on reset, the controller is in Test-Logic-Reset with the identification instruction (code 001) active. The output-float flag is 0, the serial-out enable is 0 and the drive vector is all zeros.
- R2: Five consecutive rising test-clock edges with the mode-select line high bring the controller to Test-Logic-Reset from any state. The instruction then reverts to identification.
- R3: Capture-IR loads the pattern 001 into the instruction shift stage. The instruction is shifted least-significant bit first and takes effect at Update-IR.
- R4: Instruction decode selects the data register as follows: 001 selects the identification register; 000, 010 and 100 select the boundary chain; every other code selects bypass.
- R5: The identification word holds the revision in bits 31:28, the configuration in 27:18, a vendor-defined field in 17:12 and the manufacturer code in 11:1, with bit 0 fixed at 1. It is shifted out least-significant bit first.
- R6: The bypass stage captures 0 at Capture-DR. While shifting, serial-out repeats serial-in one test-clock cycle later.
- R7: The reserved code 101 and the codes 011, 110 and 111 all behave as bypass.
- R8: The output-float flag is 1 exactly while the active instruction is 000 or 010. It changes only at Update-IR or in Test-Logic-Reset.
- R9: With a boundary instruction active, Capture-DR loads the parallel pin vector into the chain. The chain is shifted least-significant bit first and is `BSR_LEN` cells long.
- R10: Update-DR copies the chain into the drive vector only when a boundary instruction is active. With any other instruction, the drive vector is left unchanged.
- R11: Serial-out changes only on the falling test-clock edge. Its enable is 1 only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porN | input | 1 | Active-low power-on reset, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising test-clock edge |
| tdi | input | 1 | Serial data in, sampled on the rising test-clock edge |
| pinSample | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdoEnable | output | 1 | Serial-out driver enable |
| dataOutHiZ | output | 1 | Forces the device's data outputs to high impedance |
| pinDrive | output | BSR_LEN | Boundary update register contents |

## Verification
The bench builds the block with a 107-cell boundary chain and an identification word whose every field is nonzero and asymmetric. With these values, a swapped field or a reversed bit order changes the word that is read out. A chain this long also makes any off-by-one in capture or update shift every bit of the random patterns, so such an error becomes visible. All eight instruction codes are loaded in turn, and each is followed by a random data-register scan, so every decode entry is exercised, the reserved code included. The five-ones escape is started from inside Shift-DR while the float instruction is active, which shows that the escape both clears the flag and restores identification.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;

  localparam int IR_LEN = 3;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUNDARY} drSel_e;

  localparam logic [IR_LEN-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_LEN-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_LEN-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_LEN-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_LEN-1:0] IR_CAPTURE = 3'b001;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic   shIr;
    logic   capDr;
    logic   shDr;
    logic   updDr;
    drSel_e drSel;
  } tapStrobe_t;

endpackage

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl
  import tap_scan_pkg::*;
(
  input  logic              tck,
  input  logic              porN,
  input  logic              tms,
  input  logic              tdi,
  output tapState_e         state,
  output logic [IR_LEN-1:0] irValue,
  output logic              irTdoBit,
  output tapStrobe_t        strobe,
  output logic              outHiZ
);

  tapState_e         nextState;
  logic [IR_LEN-1:0] irShift;

  always_comb begin
    case (state)
      S_TLR:    nextState = tms ? S_TLR    : S_RTI;
      S_RTI:    nextState = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nextState = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nextState = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nextState = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nextState = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nextState = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nextState = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nextState = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nextState = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nextState = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nextState = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nextState = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nextState = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nextState = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nextState = tms ? S_SEL_DR : S_RTI;
      default:  nextState = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) state <= S_TLR;
    else       state <= nextState;
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      irShift <= '0;
      irValue <= OP_IDCODE;
    end else begin
      if (state == S_TLR)         irValue <= OP_IDCODE;
      else if (state == S_UPD_IR) irValue <= irShift;
      if (state == S_CAP_IR)      irShift <= IR_CAPTURE;
      else if (state == S_SH_IR)  irShift <= {tdi, irShift[IR_LEN-1:1]};
    end
  end

  assign irTdoBit = irShift[0];

  drSel_e drSel;
  always_comb begin
    case (irValue)
      OP_IDCODE:                        drSel = DR_IDENT;
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: drSel = DR_BOUNDARY;
      default:                          drSel = DR_BYPASS;
    endcase
  end

  assign outHiZ       = (irValue == OP_EXTEST) || (irValue == OP_SAMPLEZ);
  assign strobe.shIr  = (state == S_SH_IR);
  assign strobe.capDr = (state == S_CAP_DR);
  assign strobe.shDr  = (state == S_SH_DR);
  assign strobe.updDr = (state == S_UPD_DR);
  assign strobe.drSel = drSel;

endmodule

// File: rtl/tap_scan_dp.sv
module tap_scan_dp
  import tap_scan_pkg::*;
#(
  parameter int          BSR_LEN   = 107,
  parameter logic [3:0]  ID_REV    = 4'h0,
  parameter logic [9:0]  ID_PART   = 10'h123,
  parameter logic [5:0]  ID_VENDOR = 6'h2a,
  parameter logic [10:0] ID_MFR    = 11'h0b5
) (
  input  logic               tck,
  input  logic               porN,
  input  logic               tdi,
  input  tapStrobe_t         strobe,
  input  logic               irTdoBit,
  input  logic [BSR_LEN-1:0] pinSample,
  output logic [BSR_LEN-1:0] pinDrive,
  output logic               tdo,
  output logic               tdoEnable
);

  localparam int          ID_LEN  = 32;
  localparam logic [31:0] ID_WORD = {ID_REV, ID_PART, ID_VENDOR, ID_MFR, 1'b1};

  logic               bypassBit;
  logic [ID_LEN-1:0]  idShift;
  logic [BSR_LEN-1:0] bsrShift;
  logic [BSR_LEN-1:0] chainIn;
  logic               selBsr;
  logic               drBit;

  assign selBsr  = (strobe.drSel == DR_BOUNDARY);
  assign chainIn = {tdi, bsrShift[BSR_LEN-1:1]};

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) bypassBit <= 1'b0;
    else if (strobe.drSel == DR_BYPASS) begin
      if (strobe.capDr)     bypassBit <= 1'b0;
      else if (strobe.shDr) bypassBit <= tdi;
    end
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) idShift <= '0;
    else if (strobe.drSel == DR_IDENT) begin
      if (strobe.capDr)     idShift <= ID_WORD;
      else if (strobe.shDr) idShift <= {tdi, idShift[ID_LEN-1:1]};
    end
  end

  // one capture/shift cell per boundary position
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    always_ff @(posedge tck or negedge porN) begin
      if (!porN) bsrShift[i] <= 1'b0;
      else if (selBsr && strobe.capDr) bsrShift[i] <= pinSample[i];
      else if (selBsr && strobe.shDr)  bsrShift[i] <= chainIn[i];
    end
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) pinDrive <= '0;
    else if (selBsr && strobe.updDr) pinDrive <= bsrShift;
  end

  always_comb begin
    case (strobe.drSel)
      DR_IDENT:    drBit = idShift[0];
      DR_BOUNDARY: drBit = bsrShift[0];
      default:     drBit = bypassBit;
    endcase
  end

  always_ff @(negedge tck or negedge porN) begin
    if (!porN) begin
      tdo       <= 1'b0;
      tdoEnable <= 1'b0;
    end else begin
      tdo       <= strobe.shIr ? irTdoBit : (strobe.shDr ? drBit : 1'b0);
      tdoEnable <= strobe.shIr | strobe.shDr;
    end
  end

endmodule

// File: rtl/tap_scan_port.sv
module tap_scan_port
  import tap_scan_pkg::*;
#(
  parameter int          BSR_LEN   = 107,
  parameter logic [3:0]  ID_REV    = 4'h0,
  parameter logic [9:0]  ID_PART   = 10'h123,
  parameter logic [5:0]  ID_VENDOR = 6'h2a,
  parameter logic [10:0] ID_MFR    = 11'h0b5
) (
  input  logic               tck,
  input  logic               porN,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pinSample,
  output logic               tdo,
  output logic               tdoEnable,
  output logic               dataOutHiZ,
  output logic [BSR_LEN-1:0] pinDrive
);

  tapState_e         tapState;
  logic [IR_LEN-1:0] irValue;
  logic              irTdoBit;
  tapStrobe_t        strobe;

  tap_scan_ctrl u_ctrl (
    .tck      (tck),
    .porN     (porN),
    .tms      (tms),
    .tdi      (tdi),
    .state    (tapState),
    .irValue  (irValue),
    .irTdoBit (irTdoBit),
    .strobe   (strobe),
    .outHiZ   (dataOutHiZ)
  );

  tap_scan_dp #(
    .BSR_LEN   (BSR_LEN),
    .ID_REV    (ID_REV),
    .ID_PART   (ID_PART),
    .ID_VENDOR (ID_VENDOR),
    .ID_MFR    (ID_MFR)
  ) u_dp (
    .tck       (tck),
    .porN      (porN),
    .tdi       (tdi),
    .strobe    (strobe),
    .irTdoBit  (irTdoBit),
    .pinSample (pinSample),
    .pinDrive  (pinDrive),
    .tdo       (tdo),
    .tdoEnable (tdoEnable)
  );

endmodule

// File: rtl/tap_scan_port_chk.sv
module tap_scan_port_chk
  import tap_scan_pkg::*;
#(
  parameter int BSR_LEN = 107
) (
  input logic               tck,
  input logic               porN,
  input logic               tms,
  input tapState_e          tapState,
  input logic [IR_LEN-1:0]  irValue,
  input logic               tdoEnable,
  input logic               dataOutHiZ,
  input logic [BSR_LEN-1:0] pinDrive
);

  logic [2:0] onesCnt;

  always_ff @(posedge tck or negedge porN) begin
    if (!porN)                 onesCnt <= '0;
    else if (!tms)             onesCnt <= '0;
    else if (onesCnt != 3'd5)  onesCnt <= onesCnt + 3'd1;
  end

  p_five_ones_r2: assert property (@(posedge tck) disable iff (!porN)
    (onesCnt == 3'd5) |-> (tapState == S_TLR));

  p_ident_default_r1: assert property (@(posedge tck) disable iff (!porN)
    (tapState == S_TLR) |=> (irValue == OP_IDCODE));

  p_tdo_window_r11: assert property (@(posedge tck) disable iff (!porN)
    tdoEnable == ((tapState == S_SH_IR) || (tapState == S_SH_DR)));

  p_hiz_change_r8: assert property (@(posedge tck) disable iff (!porN)
    !$stable(dataOutHiZ) |-> ($past(tapState) == S_UPD_IR || $past(tapState) == S_TLR));

  p_drive_change_r10: assert property (@(posedge tck) disable iff (!porN)
    !$stable(pinDrive) |-> ($past(tapState) == S_UPD_DR));

endmodule

bind tap_scan_port tap_scan_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck        (tck),
  .porN       (porN),
  .tms        (tms),
  .tapState   (tapState),
  .irValue    (irValue),
  .tdoEnable  (tdoEnable),
  .dataOutHiZ (dataOutHiZ),
  .pinDrive   (pinDrive)
);

// File: tb/tap_scan_port_tb_top.sv
`timescale 1ns/100ps
module tap_scan_port_tb_top;

  localparam int          BSR_LEN   = 107;
  localparam logic [3:0]  ID_REV    = 4'h9;
  localparam logic [9:0]  ID_PART   = 10'h2c6;
  localparam logic [5:0]  ID_VENDOR = 6'h35;
  localparam logic [10:0] ID_MFR    = 11'h4e3;

  logic               tck = 1'b0;
  logic               porN = 1'b0;
  logic               tms = 1'b1;
  logic               tdi = 1'b1;
  logic [BSR_LEN-1:0] pinSample = '0;
  logic               tdo, tdoEnable, dataOutHiZ;
  logic [BSR_LEN-1:0] pinDrive;

  int  nChecks = 0;
  int  nFail = 0;
  int  edgeViol = 0;
  bit  finished = 1'b0;
  logic lastTdo, lastEn;

  always #2.5 tck = ~tck;

  tap_scan_port #(
    .BSR_LEN(BSR_LEN), .ID_REV(ID_REV), .ID_PART(ID_PART),
    .ID_VENDOR(ID_VENDOR), .ID_MFR(ID_MFR)
  ) dut_i (
    .tck(tck), .porN(porN), .tms(tms), .tdi(tdi), .pinSample(pinSample),
    .tdo(tdo), .tdoEnable(tdoEnable), .dataOutHiZ(dataOutHiZ), .pinDrive(pinDrive)
  );

  function automatic logic [31:0] expId();
    return {ID_REV, ID_PART, ID_VENDOR, ID_MFR, 1'b1};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic bit isBoundary(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b010) || (c == 3'b100);
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one test-clock cycle: sample outputs after the falling edge, then drive
  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    lastTdo = tdo; lastEn = tdoEnable;
    tms = m; tdi = d;
    @(posedge tck); #1;
    if (tdo !== lastTdo) edgeViol++;
  endtask

  task automatic loadIr(input logic [2:0] code, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i]);
      cap[i] = lastTdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scanDr(input int n, input logic [127:0] din,
                        output logic [127:0] dout, output bit enOk);
    step(1, 0); step(0, 0); step(0, 0);
    dout = '0; enOk = 1'b1;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = lastTdo;
      if (lastEn !== 1'b1) enOk = 1'b0;
    end
    step(1, 0); step(0, 0);
    step(0, 0);
    if (lastEn !== 1'b0) enOk = 1'b0;
  endtask

  initial begin : main
    logic [2:0]         cap;
    logic [127:0]       din, dout, expv, mask;
    logic [BSR_LEN-1:0] driveExp;
    bit                 enOk;
    void'($urandom(32'h5eed1234));
    driveExp = '0;

    repeat (3) @(posedge tck);
    @(negedge tck); #1 porN = 1'b1;
    #1;
    // R1: reset state
    check(dataOutHiZ === 1'b0 && tdoEnable === 1'b0, "R1 reset flags",
          {126'd0, dataOutHiZ, tdoEnable}, 128'd0);
    check(pinDrive === '0, "R1 reset drive", 128'(pinDrive), 128'd0);
    step(0, 0);
    scanDr(32, rnd128(), dout, enOk);
    check(dout[31:0] === expId(), "R1 R5 identification after reset", dout, 128'(expId()));
    check(enOk, "R11 enable window on ID scan", 128'(enOk), 128'd1);

    // every code, ascending, then a random pick of more
    for (int k = 0; k < 12; k++) begin
      logic [2:0] code;
      code = (k < 8) ? 3'(k) : 3'($urandom_range(0, 7));
      pinSample = BSR_LEN'(rnd128());
      loadIr(code, cap);
      check(cap === 3'b001, "R3 capture pattern", 128'(cap), 128'd1);
      check(dataOutHiZ === (code == 3'b000 || code == 3'b010), "R8 output float flag",
            128'(dataOutHiZ), 128'(code == 3'b000 || code == 3'b010));
      din = rnd128();
      if (isBoundary(code)) begin
        scanDr(BSR_LEN, din, dout, enOk);
        mask = (128'd1 << BSR_LEN) - 1;
        check((dout & mask) === 128'(pinSample), "R9 R4 boundary capture", dout & mask, 128'(pinSample));
        driveExp = din[BSR_LEN-1:0];
        check(pinDrive === driveExp, "R10 boundary update", 128'(pinDrive), 128'(driveExp));
      end else if (code == 3'b001) begin
        scanDr(40, din, dout, enOk);
        check(dout[31:0] === expId(), "R5 R4 identification word", 128'(dout[31:0]), 128'(expId()));
        check(dout[39:32] === din[7:0], "R5 identification passthrough", 128'(dout[39:32]), 128'(din[7:0]));
        check(pinDrive === driveExp, "R10 drive held under ident", 128'(pinDrive), 128'(driveExp));
      end else begin
        scanDr(40, din, dout, enOk);
        mask = (128'd1 << 40) - 1;
        expv = {din[126:0], 1'b0} & mask;
        check((dout & mask) === expv, "R6 R7 bypass delay", dout & mask, expv);
        check(pinDrive === driveExp, "R10 drive held under bypass", 128'(pinDrive), 128'(driveExp));
      end
      check(enOk, "R11 enable window", 128'(enOk), 128'd1);
    end

    // R2: escape from Shift-DR with five ones while the float instruction is active
    loadIr(3'b010, cap);
    check(dataOutHiZ === 1'b1, "R8 float set before escape", 128'(dataOutHiZ), 128'd1);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 1);
    step(1, 1);
    check(dataOutHiZ === 1'b0, "R2 escape clears float", 128'(dataOutHiZ), 128'd0);
    step(0, 0);
    scanDr(32, rnd128(), dout, enOk);
    check(dout[31:0] === expId(), "R2 identification restored", 128'(dout[31:0]), 128'(expId()));

    check(edgeViol == 0, "R11 serial-out stable at rising edge", 128'(edgeViol), 128'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge tck);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule